// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the write side of a NOR-style flash device and turns bus writes into operation requests. A write cycle is framed by the active-low write strobe. The address is captured when the strobe goes low and the data is taken when it goes high. Every command opens with two unlock writes. Each one is a fixed data code written to a fixed word address. A command code follows, and for some commands further cycles follow it. When a sequence completes, the block raises a single-cycle request for one of these operations: program, whole-array erase, single-block erase, fast-program setup, ID entry, reset or suspend. The captured operand address and data are presented alongside the request.

The block also tracks two modes. The first is the read mode, which is either array read or ID read. In ID read the block supplies identification words on a read-data output. The second is a fast-program mode, in which a program needs no unlock prefix. Two inputs gate the decoder. A supply lockout input makes every write invisible. A busy input, driven by the operation engine, lets only the reset and suspend codes through.

Top module: `fcs_decoder`

## Requirements
- R1: After reset all request outputs are low, `id_mode` and `fast_mode` are 0, and `cmd_addr` and `cmd_data` are 0.
- R2: The unlock prefix is a write of data AAh at word address 555h followed by a write of 55h at 2AAh. Only the low 8 data bits and the low 11 address bits are compared, so address bits above bit 10 are ignored.
- R3: The program sequence is the unlock prefix, then A0h at 555h, then one write of any address and data. That fourth write raises `req_prog` and loads `cmd_addr` and `cmd_data` with the address and data of that write.
- R4: The whole-array erase sequence is the unlock prefix, then 80h at 555h, then a second unlock prefix, then 10h at 555h. The sixth write raises `req_chip_erase`.
- R5: The single-block erase sequence uses the same five writes as R4, followed by 30h at any address. It raises `req_blk_erase` and loads `cmd_addr` with that address.
- R6: The unlock prefix followed by 20h at 555h raises `req_fast_set` and sets `fast_mode`. While `fast_mode` is 1, a lone write of A0h at any address arms a program, and the next write completes it as in R3.
- R7: The unlock prefix followed by 90h at an address whose low 11 bits are 555h raises `req_id_entry` and sets `id_mode`. A write of F0h at any address, in any sequence state other than awaiting program data, raises `req_reset` and clears `id_mode` and `fast_mode`.
- R8: `id_rdata` is 0 while `id_mode` is 0. While `id_mode` is 1 it follows the live `addr[1:0]`: 0 gives 0098h, 1 gives 009Ah, 2 gives `blk_prot` in bit 0 with all other bits 0, and 3 gives 0.
- R9: The address is taken from the clock cycle in which `we_n` is first sampled low. The data is taken from the cycle in which `we_n` is first sampled high again. The resulting request is high for exactly one cycle, starting at the clock edge that samples that rising strobe.
- R10: Any write that does not match the next expected step returns the sequence to idle without a request, so a command then needs a fresh unlock prefix.
- R11: While `lockout` is 1, writes have no effect. This includes F0h: no request is raised, no mode changes and the sequence state stays where it was.
- R12: While `busy` is 1, a write of F0h acts as in R7 and a write of B0h raises `req_suspend`. Any other write returns the sequence to idle with no request. B0h while not busy is treated as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Active-low write strobe, sampled on the clock |
| addr | input | AW | Word address, also selects the ID read word |
| wdata | input | DW | Write data |
| lockout | input | 1 | Low-supply lockout; writes are ignored while it is 1 |
| busy | input | 1 | An operation is running |
| blk_prot | input | 1 | Protection state of the addressed block |
| req_prog | output | 1 | Program request pulse |
| req_chip_erase | output | 1 | Whole-array erase request pulse |
| req_blk_erase | output | 1 | Block erase request pulse |
| req_fast_set | output | 1 | Fast-program setup pulse |
| req_id_entry | output | 1 | ID read entry pulse |
| req_reset | output | 1 | Reset command pulse |
| req_suspend | output | 1 | Suspend request pulse |
| cmd_addr | output | AW | Captured operand address |
| cmd_data | output | DW | Captured program data |
| id_mode | output | 1 | 1 when the read mode is ID read |
| fast_mode | output | 1 | 1 when fast-program mode is active |
| id_rdata | output | DW | Identification read word |

## Verification
The assertions assume that `we_n` changes no faster than the clock, so a high-to-low-to-high strobe spans at least two samples. They also assume that `wdata` and `lockout` are steady in the cycle that samples the rising strobe. The stimulus task holds the strobe low for two cycles and changes inputs only on the falling clock edge. It also drives a deliberately wrong address while the strobe is still low, so that capturing the address at the wrong edge shows up as a mismatch. Each write is followed by an idle cycle, which keeps request pulses separated and lets the behavioural model compare every output on every clock.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNL1,
      ST_CMD,
      ST_PROG,
      ST_ER1,
      ST_ER2,
      ST_ER3
   } seq_st_e;

   localparam logic [7:0] C_UNL_A  = 8'hAA;
   localparam logic [7:0] C_UNL_B  = 8'h55;
   localparam logic [7:0] C_PROG   = 8'hA0;
   localparam logic [7:0] C_ERASE  = 8'h80;
   localparam logic [7:0] C_CHIP   = 8'h10;
   localparam logic [7:0] C_BLOCK  = 8'h30;
   localparam logic [7:0] C_FAST   = 8'h20;
   localparam logic [7:0] C_IDENT  = 8'h90;
   localparam logic [7:0] C_RESET  = 8'hF0;
   localparam logic [7:0] C_SUSP   = 8'hB0;
endpackage

// File: rtl/fcs_strobe.sv
module fcs_strobe #(
   parameter int AW = 21
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   output logic          wr_evt,
   output logic [AW-1:0] a_lat
);
   logic we_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_q  <= 1'b1;
         a_lat <= '0;
      end else begin
         we_q <= we_n;
         if (we_q && !we_n) a_lat <= addr;
      end
   end

   assign wr_evt = !we_q && we_n;
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
   import fcs_pkg::*;
#(
   parameter int AW = 21,
   parameter int DW = 16,
   parameter int CMP_BITS = 11,
   parameter logic [CMP_BITS-1:0] UNL_ADDR_A = 'h555,
   parameter logic [CMP_BITS-1:0] UNL_ADDR_B = 'h2AA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_evt,
   input  logic [AW-1:0] a_lat,
   input  logic [DW-1:0] wdata,
   input  logic          lockout,
   input  logic          busy,
   output logic          req_prog,
   output logic          req_chip_erase,
   output logic          req_blk_erase,
   output logic          req_fast_set,
   output logic          req_id_entry,
   output logic          req_reset,
   output logic          req_suspend,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data,
   output logic          id_mode,
   output logic          fast_mode
);
   seq_st_e st, st_n;
   logic hit_a, hit_b;
   logic [7:0] dcode;
   logic p_prog, p_chip, p_blk, p_fast, p_id, p_rst, p_sus;
   logic id_n, fast_n;
   logic [AW-1:0] ca_n;
   logic [DW-1:0] cd_n;

   assign dcode = wdata[7:0];

   generate
      if (CMP_BITS == AW) begin : g_full_cmp
         assign hit_a = (a_lat == UNL_ADDR_A);
         assign hit_b = (a_lat == UNL_ADDR_B);
      end else begin : g_low_cmp
         assign hit_a = (a_lat[CMP_BITS-1:0] == UNL_ADDR_A);
         assign hit_b = (a_lat[CMP_BITS-1:0] == UNL_ADDR_B);
      end
   endgenerate

   always_comb begin
      st_n   = st;
      id_n   = id_mode;
      fast_n = fast_mode;
      ca_n   = cmd_addr;
      cd_n   = cmd_data;
      p_prog = 1'b0;
      p_chip = 1'b0;
      p_blk  = 1'b0;
      p_fast = 1'b0;
      p_id   = 1'b0;
      p_rst  = 1'b0;
      p_sus  = 1'b0;
      if (wr_evt && !lockout) begin
         st_n = ST_IDLE;
         if (busy) begin
            if (dcode == C_RESET) begin
               p_rst  = 1'b1;
               id_n   = 1'b0;
               fast_n = 1'b0;
            end else if (dcode == C_SUSP) begin
               p_sus = 1'b1;
            end
         end else if (st == ST_PROG) begin
            p_prog = 1'b1;
            ca_n   = a_lat;
            cd_n   = wdata;
         end else if (dcode == C_RESET) begin
            p_rst  = 1'b1;
            id_n   = 1'b0;
            fast_n = 1'b0;
         end else begin
            case (st)
               ST_IDLE: begin
                  if (hit_a && dcode == C_UNL_A) st_n = ST_UNL1;
                  else if (fast_mode && dcode == C_PROG) st_n = ST_PROG;
               end
               ST_UNL1: if (hit_b && dcode == C_UNL_B) st_n = ST_CMD;
               ST_CMD: begin
                  if (hit_a) begin
                     case (dcode)
                        C_PROG:  st_n = ST_PROG;
                        C_ERASE: st_n = ST_ER1;
                        C_FAST: begin
                           p_fast = 1'b1;
                           fast_n = 1'b1;
                        end
                        C_IDENT: begin
                           p_id = 1'b1;
                           id_n = 1'b1;
                        end
                        default: st_n = ST_IDLE;
                     endcase
                  end
               end
               ST_ER1: if (hit_a && dcode == C_UNL_A) st_n = ST_ER2;
               ST_ER2: if (hit_b && dcode == C_UNL_B) st_n = ST_ER3;
               ST_ER3: begin
                  if (hit_a && dcode == C_CHIP) begin
                     p_chip = 1'b1;
                  end else if (dcode == C_BLOCK) begin
                     p_blk = 1'b1;
                     ca_n  = a_lat;
                  end
               end
               default: st_n = ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st             <= ST_IDLE;
         id_mode        <= 1'b0;
         fast_mode      <= 1'b0;
         cmd_addr       <= '0;
         cmd_data       <= '0;
         req_prog       <= 1'b0;
         req_chip_erase <= 1'b0;
         req_blk_erase  <= 1'b0;
         req_fast_set   <= 1'b0;
         req_id_entry   <= 1'b0;
         req_reset      <= 1'b0;
         req_suspend    <= 1'b0;
      end else begin
         st             <= st_n;
         id_mode        <= id_n;
         fast_mode      <= fast_n;
         cmd_addr       <= ca_n;
         cmd_data       <= cd_n;
         req_prog       <= p_prog;
         req_chip_erase <= p_chip;
         req_blk_erase  <= p_blk;
         req_fast_set   <= p_fast;
         req_id_entry   <= p_id;
         req_reset      <= p_rst;
         req_suspend    <= p_sus;
      end
   end
endmodule

// File: rtl/fcs_idmux.sv
module fcs_idmux #(
   parameter int AW = 21,
   parameter int DW = 16,
   parameter logic [DW-1:0] MFR_WORD = 'h0098,
   parameter logic [DW-1:0] DEV_WORD = 'h009A
) (
   input  logic          id_mode,
   input  logic [AW-1:0] addr,
   input  logic          blk_prot,
   output logic [DW-1:0] id_rdata
);
   localparam logic [DW-1:0] PROT_ONE = DW'(1);

   always_comb begin
      id_rdata = '0;
      if (id_mode) begin
         case (addr[1:0])
            2'd0:    id_rdata = MFR_WORD;
            2'd1:    id_rdata = DEV_WORD;
            2'd2:    id_rdata = blk_prot ? PROT_ONE : '0;
            default: id_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/fcs_decoder.sv
module fcs_decoder #(
   parameter int AW = 21,
   parameter int DW = 16,
   parameter int CMP_BITS = 11,
   parameter logic [DW-1:0] MFR_WORD = 'h0098,
   parameter logic [DW-1:0] DEV_WORD = 'h009A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          lockout,
   input  logic          busy,
   input  logic          blk_prot,
   output logic          req_prog,
   output logic          req_chip_erase,
   output logic          req_blk_erase,
   output logic          req_fast_set,
   output logic          req_id_entry,
   output logic          req_reset,
   output logic          req_suspend,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data,
   output logic          id_mode,
   output logic          fast_mode,
   output logic [DW-1:0] id_rdata
);
   generate
      if (CMP_BITS < 11 || CMP_BITS > AW) begin : g_bad_cmp
         $error("fcs_decoder: CMP_BITS must lie between 11 and AW");
      end
      if (DW < 8) begin : g_bad_dw
         $error("fcs_decoder: DW must be at least 8");
      end
      if (AW < 2) begin : g_bad_aw
         $error("fcs_decoder: AW must be at least 2");
      end
   endgenerate

   logic          wr_evt;
   logic [AW-1:0] a_lat;

   fcs_strobe #(.AW(AW)) u_strobe (
      .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr),
      .wr_evt(wr_evt), .a_lat(a_lat)
   );

   fcs_seq #(
      .AW(AW), .DW(DW), .CMP_BITS(CMP_BITS),
      .UNL_ADDR_A(CMP_BITS'('h555)), .UNL_ADDR_B(CMP_BITS'('h2AA))
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .a_lat(a_lat),
      .wdata(wdata), .lockout(lockout), .busy(busy),
      .req_prog(req_prog), .req_chip_erase(req_chip_erase),
      .req_blk_erase(req_blk_erase), .req_fast_set(req_fast_set),
      .req_id_entry(req_id_entry), .req_reset(req_reset),
      .req_suspend(req_suspend), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .id_mode(id_mode), .fast_mode(fast_mode)
   );

   fcs_idmux #(.AW(AW), .DW(DW), .MFR_WORD(MFR_WORD), .DEV_WORD(DEV_WORD)) u_idmux (
      .id_mode(id_mode), .addr(addr), .blk_prot(blk_prot), .id_rdata(id_rdata)
   );
endmodule

// File: rtl/fcs_decoder_chk.sv
module fcs_decoder_chk #(
   parameter int AW = 21,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          we_n,
   input logic [DW-1:0] wdata,
   input logic          lockout,
   input logic          busy,
   input logic          req_prog,
   input logic          req_chip_erase,
   input logic          req_blk_erase,
   input logic          req_fast_set,
   input logic          req_id_entry,
   input logic          req_reset,
   input logic          req_suspend,
   input logic          id_mode,
   input logic          fast_mode,
   input logic [DW-1:0] id_rdata
);
   logic       we_d;
   logic       rise;
   logic [6:0] reqs;

   always_ff @(posedge clk) begin
      if (!rst_n) we_d <= 1'b1;
      else        we_d <= we_n;
   end

   assign rise = !we_d && we_n;
   assign reqs = {req_prog, req_chip_erase, req_blk_erase, req_fast_set,
                  req_id_entry, req_reset, req_suspend};

   a_r11_lockout_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && lockout) |=> (reqs == 7'd0));

   a_r12_busy_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && busy && wdata[7:0] != 8'hF0 && wdata[7:0] != 8'hB0) |=> (reqs == 7'd0));

   a_r12_suspend_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_suspend |-> $past(busy));

   a_r9_req_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (reqs != 7'd0) |-> $past(rise));

   a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reqs));

   a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (reqs != 7'd0) |=> (reqs == 7'd0));

   a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      req_reset |-> (!id_mode && !fast_mode));

   a_r7_id_sets: assert property (@(posedge clk) disable iff (!rst_n)
      req_id_entry |-> id_mode);

   a_r6_fast_sets: assert property (@(posedge clk) disable iff (!rst_n)
      req_fast_set |-> fast_mode);

   a_r8_array_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !id_mode |-> (id_rdata == '0));
endmodule

bind fcs_decoder fcs_decoder_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .we_n(we_n), .wdata(wdata), .lockout(lockout),
   .busy(busy), .req_prog(req_prog), .req_chip_erase(req_chip_erase),
   .req_blk_erase(req_blk_erase), .req_fast_set(req_fast_set),
   .req_id_entry(req_id_entry), .req_reset(req_reset), .req_suspend(req_suspend),
   .id_mode(id_mode), .fast_mode(fast_mode), .id_rdata(id_rdata)
);

// File: tb/fcs_decoder_tb_top.sv
`timescale 1ns/1ps
module fcs_decoder_tb_top;
   localparam int AW = 21;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          lockout = 1'b0;
   logic          busy = 1'b0;
   logic          blk_prot = 1'b0;
   logic          req_prog, req_chip_erase, req_blk_erase, req_fast_set;
   logic          req_id_entry, req_reset, req_suspend, id_mode, fast_mode;
   logic [AW-1:0] cmd_addr;
   logic [DW-1:0] cmd_data, id_rdata;

   always #5 clk = ~clk;

   fcs_decoder #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
      .lockout(lockout), .busy(busy), .blk_prot(blk_prot),
      .req_prog(req_prog), .req_chip_erase(req_chip_erase),
      .req_blk_erase(req_blk_erase), .req_fast_set(req_fast_set),
      .req_id_entry(req_id_entry), .req_reset(req_reset),
      .req_suspend(req_suspend), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .id_mode(id_mode), .fast_mode(fast_mode), .id_rdata(id_rdata)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   // behavioural reference: step = how many writes of the current sequence matched
   int step = 0;           // 0 idle,1 one unlock,2 command expected,3 prog data,4..6 erase steps
   bit m_we = 1;
   int m_alat = 0;
   int m_pulse = 0;        // 0 none,1 prog,2 chip,3 blk,4 fast,5 id,6 reset,7 suspend
   bit m_id = 0, m_fast = 0;
   int m_caddr = 0, m_cdata = 0;
   int cnt[8] = '{default:0};

   always @(posedge clk) begin
      int a11, d8;
      if (!rst_n) begin
         step = 0; m_we = 1; m_alat = 0; m_pulse = 0;
         m_id = 0; m_fast = 0; m_caddr = 0; m_cdata = 0;
      end else begin
         m_pulse = 0;
         if (m_we && !we_n) m_alat = int'(addr);
         if (!m_we && we_n && !lockout) begin
            a11 = m_alat % 2048;
            d8  = int'(wdata) % 256;
            if (busy) begin
               step = 0;
               if (d8 == 'hF0) begin m_pulse = 6; m_id = 0; m_fast = 0; end
               else if (d8 == 'hB0) m_pulse = 7;
            end else if (step == 3) begin
               step = 0; m_pulse = 1; m_caddr = m_alat; m_cdata = int'(wdata);
            end else if (d8 == 'hF0) begin
               step = 0; m_pulse = 6; m_id = 0; m_fast = 0;
            end else if (step == 0 && a11 == 'h555 && d8 == 'hAA) step = 1;
            else if (step == 0 && m_fast && d8 == 'hA0) step = 3;
            else if (step == 1 && a11 == 'h2AA && d8 == 'h55) step = 2;
            else if (step == 2 && a11 == 'h555 && d8 == 'hA0) step = 3;
            else if (step == 2 && a11 == 'h555 && d8 == 'h80) step = 4;
            else if (step == 2 && a11 == 'h555 && d8 == 'h20) begin step = 0; m_pulse = 4; m_fast = 1; end
            else if (step == 2 && a11 == 'h555 && d8 == 'h90) begin step = 0; m_pulse = 5; m_id = 1; end
            else if (step == 4 && a11 == 'h555 && d8 == 'hAA) step = 5;
            else if (step == 5 && a11 == 'h2AA && d8 == 'h55) step = 6;
            else if (step == 6 && a11 == 'h555 && d8 == 'h10) begin step = 0; m_pulse = 2; end
            else if (step == 6 && d8 == 'h30) begin step = 0; m_pulse = 3; m_caddr = m_alat; end
            else step = 0;
         end
         m_we = we_n;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_id(input bit idm, input int a, input bit bp);
      if (!idm) return 0;
      case (a % 4)
         0: return 'h0098;
         1: return 'h009A;
         2: return bp ? 1 : 0;
         default: return 0;
      endcase
   endfunction

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 req_prog",        int'(req_prog),       int'(m_pulse == 1));
         chk("R4 req_chip_erase",  int'(req_chip_erase), int'(m_pulse == 2));
         chk("R5 req_blk_erase",   int'(req_blk_erase),  int'(m_pulse == 3));
         chk("R6 req_fast_set",    int'(req_fast_set),   int'(m_pulse == 4));
         chk("R7 req_id_entry",    int'(req_id_entry),   int'(m_pulse == 5));
         chk("R7 req_reset",       int'(req_reset),      int'(m_pulse == 6));
         chk("R12 req_suspend",    int'(req_suspend),    int'(m_pulse == 7));
         chk("R9 cmd_addr",        int'(cmd_addr),       m_caddr);
         chk("R3 cmd_data",        int'(cmd_data),       m_cdata);
         chk("R7 id_mode",         int'(id_mode),        int'(m_id));
         chk("R6 fast_mode",       int'(fast_mode),      int'(m_fast));
         chk("R8 id_rdata",        int'(id_rdata),       exp_id(m_id, int'(addr), blk_prot));
         if (req_prog) cnt[1]++;
         if (req_chip_erase) cnt[2]++;
         if (req_blk_erase) cnt[3]++;
         if (req_fast_set) cnt[4]++;
         if (req_id_entry) cnt[5]++;
         if (req_reset) cnt[6]++;
         if (req_suspend) cnt[7]++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 100000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=finish", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr = AW'(a); we_n = 1'b0;
      @(negedge clk);
      addr = ~AW'(a); wdata = DW'(d);
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic unlock(input int hi);
      wr(hi + 'h555, 'hAA);
      wr(hi + 'h2AA, 'h55);
   endtask

   int base[8];
   task automatic snap();
      for (int i = 0; i < 8; i++) base[i] = cnt[i];
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 requests", int'({req_prog, req_chip_erase, req_blk_erase, req_fast_set,
                                req_id_entry, req_reset, req_suspend}), 0);
      chk("R1 id_mode", int'(id_mode), 0);
      chk("R1 fast_mode", int'(fast_mode), 0);
      chk("R1 cmd_addr", int'(cmd_addr), 0);
      chk("R1 cmd_data", int'(cmd_data), 0);

      // R3 program, R9 address from the falling strobe
      snap();
      unlock(0); wr('h555, 'hA0); wr('h12345, 'hBEEF);
      chk("R3 program count", cnt[1] - base[1], 1);
      chk("R9 address captured at fall", int'(cmd_addr), 'h12345);
      chk("R3 program data", int'(cmd_data), 'hBEEF);

      // R2 upper address bits ignored
      snap();
      unlock('h1F000); wr('h0A555, 'h12A0); wr('h00777, 'h0F0F);
      chk("R2 unlock upper bits", cnt[1] - base[1], 1);
      chk("R2 program data", int'(cmd_data), 'h0F0F);

      // R4 chip erase
      snap();
      unlock(0); wr('h555, 'h80); unlock(0); wr('h555, 'h10);
      chk("R4 chip erase count", cnt[2] - base[2], 1);

      // R5 block erase
      snap();
      unlock(0); wr('h555, 'h80); unlock(0); wr('h18000, 'h30);
      chk("R5 block erase count", cnt[3] - base[3], 1);
      chk("R5 block address", int'(cmd_addr), 'h18000);

      // R10 mismatch returns to idle
      snap();
      wr('h555, 'hAA); wr('h2AB, 'h55); wr('h555, 'hA0); wr('h00100, 'h1234);
      wr('h555, 'hA0); wr('h00200, 'h5678);
      chk("R10 no program after mismatch", cnt[1] - base[1], 0);
      chk("R10 cmd_data unchanged", int'(cmd_data), 'h0F0F);

      // R7/R8 ID read
      snap();
      unlock(0); wr('h8555, 'h90);
      chk("R7 id entry count", cnt[5] - base[5], 1);
      chk("R7 id_mode set", int'(id_mode), 1);
      @(negedge clk); addr = AW'(0); @(negedge clk);
      chk("R8 manufacturer word", int'(id_rdata), 'h0098);
      addr = AW'(1); @(negedge clk);
      chk("R8 device word", int'(id_rdata), 'h009A);
      blk_prot = 1'b1; addr = AW'('h18002); @(negedge clk);
      chk("R8 protect word", int'(id_rdata), 'h0001);
      blk_prot = 1'b0;

      // R11 lockout ignores everything, including reset
      snap();
      lockout = 1'b1;
      unlock(0); wr('h555, 'hA0); wr('h00400, 'hAAAA); wr('h0, 'hF0);
      lockout = 1'b0;
      chk("R11 no requests under lockout", cnt[1] + cnt[6] - base[1] - base[6], 0);
      chk("R11 id_mode kept", int'(id_mode), 1);

      // R7 reset leaves ID read
      snap();
      wr('h0, 'hF0);
      chk("R7 reset count", cnt[6] - base[6], 1);
      chk("R7 id_mode cleared", int'(id_mode), 0);
      chk("R8 array read zero", int'(id_rdata), 0);

      // R6 fast program
      snap();
      unlock(0); wr('h555, 'h20);
      chk("R6 fast set count", cnt[4] - base[4], 1);
      wr('h00033, 'hA0); wr('h00500, 'hC0DE);
      chk("R6 fast program count", cnt[1] - base[1], 1);
      chk("R6 fast program addr", int'(cmd_addr), 'h00500);
      wr('h0, 'hF0);
      chk("R6 fast_mode cleared", int'(fast_mode), 0);

      // R12 busy filter
      snap();
      busy = 1'b1;
      unlock(0); wr('h555, 'hA0); wr('h00600, 'h1111);
      chk("R12 no program while busy", cnt[1] - base[1], 0);
      wr('h0, 'hB0);
      chk("R12 suspend while busy", cnt[7] - base[7], 1);
      wr('h0, 'hF0);
      chk("R12 reset while busy", cnt[6] - base[6], 1);
      busy = 1'b0;
      wr('h0, 'hB0);
      chk("R12 suspend ignored when idle", cnt[7] - base[7], 1);

      repeat (4) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule